// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides one unsigned operand by another over several clock cycles and produces one quotient bit per cycle. A caller presents a dividend and a divisor and pulses `start` while the block is idle. The block captures both operands, clears its partial remainder and then runs one shift, trial-subtract and restore step per cycle. When every quotient bit is settled it raises `done` for a single cycle. The quotient and remainder stay on the outputs until the next accepted start.

Each step shifts the concatenation of the partial remainder and the quotient register left by one place, then subtracts the divisor from the partial remainder. The partial remainder is one bit wider than the operands, so the sign of the trial difference is a plain bit. When that bit is set, the quotient bit is 0 and the divisor is added back to the difference. Otherwise the quotient bit is 1 and the difference is kept. A zero divisor is not iterated. It is reported at once through a dedicated flag.

Top module: `rdiv_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done` and `div_zero` are 0 after that edge.
- R2: A start with a nonzero divisor that is accepted at an edge makes `busy` high for exactly W cycles. `done` is then high for exactly one cycle, in the cycle that follows the W-th edge after the accepting edge. `busy` and `done` are never high together.
- R3: When `done` is high after a nonzero divisor, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor, both unsigned. For W = 4, dividend 0111 and divisor 0011 give quotient 0010 and remainder 0001.
- R4: For every nonzero-divisor result, `remainder` is less than the divisor and quotient*divisor + remainder equals the dividend.
- R5: A start with divisor 0 raises `done` together with `div_zero` in the cycle right after the accepting edge, and `busy` never rises. That result has `quotient` all ones and `remainder` equal to the dividend.
- R6: `start` is accepted only when both `busy` and `done` are low. A start pulse in any other cycle changes neither the result nor the timing of the operation in progress, and causes no extra `done`.
- R7: `div_zero` keeps its value until the next accepted start. It is cleared by an accepted start with a nonzero divisor.
- R8: The edge cases divisor > dividend (quotient 0, remainder = dividend), divisor 1 (quotient = dividend, remainder 0) and dividend 0 follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Requests a division; accepted only while idle |
| dividend | input | W | Unsigned dividend, sampled on an accepted start |
| divisor | input | W | Unsigned divisor, sampled on an accepted start |
| busy | output | 1 | High during the W iteration cycles |
| done | output | 1 | One-cycle pulse when the result is ready |
| div_zero | output | 1 | Set when the captured divisor was zero |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
Several properties are checked on every cycle. `busy` and `done` are never high together, `done` lasts a single cycle, and a run of `busy` is exactly W cycles long and always ends in `done`. A zero-divisor `done` never follows a busy cycle. For each nonzero result, the remainder is below the captured divisor and quotient times divisor plus remainder rebuilds the dividend. Only the bench scenarios show the rest: the exact values across every 4-bit operand pair, the all-ones and pass-through results for a zero divisor, the clearing of the zero flag, and that start pulses during a run or in the done cycle leave the result and its latency untouched.

// File: rtl/rdiv_pkg.sv
// Shared types for the restoring divider.
// Assumes: nothing beyond standard SystemVerilog packages.
package rdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } rdiv_state_e;
endpackage

// File: rtl/rdiv_step.sv
// One restoring-division iteration, purely combinational.
// Shifts {A,Q} left one place, subtracts M from A, and restores by adding M back
// when the trial difference is negative (its top bit set).
// Assumes: a_in is W+1 bits and its top bit is 0 on entry.
module rdiv_step #(
    parameter int W = 4
) (
    input  logic [W:0]   a_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] m_in,
    output logic [W:0]   a_out,
    output logic [W-1:0] q_out
);
    localparam int AW = W + 1;

    logic [AW-1:0] a_shift;
    logic [AW-1:0] m_ext;
    logic [AW-1:0] trial;
    logic [AW-1:0] restored;
    logic          negative;

    // Build the shifted partial remainder and the trial difference.
    always_comb begin
        a_shift  = {a_in[W-1:0], q_in[W-1]};
        m_ext    = {1'b0, m_in};
        trial    = a_shift - m_ext;
        restored = trial + m_ext;
        negative = trial[AW-1];
    end

    // Choose the restored or kept remainder and append the quotient bit.
    always_comb begin
        a_out = negative ? restored : trial;
        q_out = (q_in << 1) | {{(W-1){1'b0}}, ~negative};
    end
endmodule

// File: rtl/rdiv_ctrl.sv
// Sequencer for the restoring divider.
// Accepts start only in idle, runs W iterations (none for a zero divisor),
// then holds the finish state for exactly one cycle.
// Assumes: div_is_zero is valid in the same cycle as start.
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic div_is_zero,
    output logic load,
    output logic iterate,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rdiv_state_e   state;
    logic [CW-1:0] cnt;

    // Decode the state into the strobes used by the datapath and the ports.
    always_comb begin
        load    = start && (state == ST_IDLE);
        iterate = (state == ST_RUN);
        busy    = (state == ST_RUN);
        done    = (state == ST_FIN);
    end

    // Advance the state machine and the iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= div_is_zero ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (cnt == LAST) begin
                        state <= ST_FIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rdiv_datapath.sv
// Registers of the restoring divider: partial remainder A (W+1 bits),
// dividend/quotient Q and divisor M, plus the zero-divisor flag.
// Assumes: load and iterate are never high in the same cycle.
module rdiv_datapath #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         iterate,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         div_is_zero,
    output logic         div_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic [W:0]   a_reg;
    logic [W-1:0] q_reg;
    logic [W-1:0] m_reg;
    logic [W:0]   a_next;
    logic [W-1:0] q_next;

    // Flag a zero divisor at the input so the sequencer can skip iterating.
    always_comb div_is_zero = (divisor == '0);

    rdiv_step #(.W(W)) u_step (
        .a_in  (a_reg),
        .q_in  (q_reg),
        .m_in  (m_reg),
        .a_out (a_next),
        .q_out (q_next)
    );

    // Load operands on start, or take one iteration per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reg    <= '0;
            q_reg    <= '0;
            m_reg    <= '0;
            div_zero <= 1'b0;
        end else if (load) begin
            m_reg    <= divisor;
            div_zero <= div_is_zero;
            if (div_is_zero) begin
                a_reg <= {1'b0, dividend};
                q_reg <= '1;
            end else begin
                a_reg <= '0;
                q_reg <= dividend;
            end
        end else if (iterate) begin
            a_reg <= a_next;
            q_reg <= q_next;
        end
    end

    // Expose the quotient and the low W bits of the remainder.
    always_comb begin
        quotient  = q_reg;
        remainder = a_reg[W-1:0];
    end
endmodule

// File: rtl/rdiv_top.sv
// Multi-cycle unsigned restoring divider, one quotient bit per cycle.
// Assumes: start is a level sampled on rising edges; operands valid with it.
module rdiv_top #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic load;
    logic iterate;
    logic div_is_zero;

    rdiv_ctrl #(.W(W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .div_is_zero (div_is_zero),
        .load        (load),
        .iterate     (iterate),
        .busy        (busy),
        .done        (done)
    );

    rdiv_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .iterate     (iterate),
        .dividend    (dividend),
        .divisor     (divisor),
        .div_is_zero (div_is_zero),
        .div_zero    (div_zero),
        .quotient    (quotient),
        .remainder   (remainder)
    );
endmodule

// File: rtl/rdiv_checker.sv
// Port-level properties of the restoring divider, attached by bind.
// Keeps its own copy of the accepted operands and a busy-run counter.
module rdiv_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int CW = $clog2(W + 2);

    logic [CW-1:0]  run_len;
    logic [W-1:0]   cap_a;
    logic [W-1:0]   cap_m;
    logic [2*W:0]   rebuilt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // Capture operands whenever a start is accepted at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_m <= '0;
        end else if (start && !busy && !done) begin
            cap_a <= dividend;
            cap_m <= divisor;
        end
    end

    // Rebuild the dividend from the outputs.
    always_comb rebuilt = (2*W+1)'(quotient) * (2*W+1)'(cap_m) + (2*W+1)'(remainder);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy && !done && !div_zero));

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == CW'(W) && done));

    assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (remainder < cap_m));

    assert_rebuild_dividend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (rebuilt == (2*W+1)'(cap_a)));

    assert_zero_no_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> !$past(busy));

    assert_busy_ends_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
endmodule

bind rdiv_top rdiv_checker #(.W(W)) u_rdiv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/tb_rdiv_top.sv
// Scoreboard bench: the driver queues expected results, the monitor checks them on done.
module tb_rdiv_top;
    localparam int W      = 4;
    localparam int CLK_NS = 10;
    localparam int WDOG   = 100000;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         dz;
        int           lat;
        int           t0;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic         div_zero;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t sb[$];

    rdiv_top #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .div_zero  (div_zero),
        .quotient  (quotient),
        .remainder (remainder)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Driver: wait for idle, pulse start, queue the expected result.
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit noise);
        exp_t e;
        while (busy || done) @(negedge clk);
        e.dz  = (b == '0);
        e.q   = e.dz ? '1 : a / b;
        e.r   = e.dz ? a : a % b;
        e.lat = e.dz ? 1 : W + 1;
        e.t0  = cyc;
        sb.push_back(e);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == !e.dz, e.dz ? "R5 busy stays low" : "R2 busy after start", busy, !e.dz);
        if (noise) begin
            // R6: start pulses while busy and during done must be ignored
            for (int i = 0; i < W + 1; i++) begin
                dividend = ~a;
                divisor  = 1;
                start    = 1'b1;
                @(negedge clk);
            end
            start = 1'b0;
            repeat (3) @(negedge clk);
            check(!busy && !done, "R6 no restart from ignored start", busy, 0);
        end
    endtask

    // Monitor: compare every done pulse against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q, e.dz ? "R5 quotient" : "R3 quotient", quotient, e.q);
                check(remainder == e.r, e.dz ? "R5 remainder" : "R3 remainder", remainder, e.r);
                check(div_zero == e.dz, "R7 div_zero flag", div_zero, e.dz);
                check(cyc - e.t0 == e.lat, e.dz ? "R5 latency" : "R2 latency", cyc - e.t0, e.lat);
                check(!busy, "R2 busy low with done", busy, 0);
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WDOG, WDOG);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !div_zero, "R1 reset outputs", {busy, done, div_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(4'd7, 4'd3, 1'b0);    // R3 worked case: 0010 rem 0001
        run_div(4'd0, 4'd5, 1'b0);    // R8 zero dividend
        run_div(4'd3, 4'd9, 1'b0);    // R8 divisor above dividend
        run_div(4'd15, 4'd1, 1'b0);   // R8 divide by one
        run_div(4'd15, 4'd15, 1'b0);
        run_div(4'd9, 4'd0, 1'b0);    // R5 zero divisor
        run_div(4'd12, 4'd5, 1'b0);   // R7 flag cleared
        run_div(4'd13, 4'd4, 1'b1);   // R6 ignored starts
        run_div(4'd0, 4'd0, 1'b0);    // R5 zero over zero
        run_div(4'd14, 4'd3, 1'b1);   // R6 again, after a zero divisor

        // R3 R4 exhaustive sweep of 4-bit operands
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_div(W'(a), W'(b), 1'b0);
            end
        end

        repeat (W + 4) @(negedge clk);
        check(sb.size() == 0, "R2 all results delivered", sb.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule